// File: doc/BRIEF.md
# Paged Program Counter with In-Page Indirect Jump

This block keeps the 12-bit fetch address of a small processor whose program store is divided into 256-location pages. The page of an address is its upper 4 bits, so two addresses share a page exactly when their top hexadecimal digit matches. Each fetched byte enters on a valid/ready stream together with its decoded instruction class and the current value of an 8-bit register pair. The counter then moves to its next value.

Three kinds of movement are supported. Ordinary bytes advance the counter by one, wrapping from 0xFFF to 0x000. A two-byte jump, or a two-byte call that uses the same path, reaches any address: the low nibble of its first byte gives the page, and its second byte gives the offset. A one-byte indirect jump stays in a page but replaces only the offset, taking the low 8 bits from the register pair. It takes the page from the counter after it has already stepped past the jump. So an indirect jump at the last location of a page lands on the following page, and one at 0xFFF lands on page 0.

Back-pressure: a byte is consumed only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low during reset and high from the first cycle after it. A producer may drop `in_valid` at any time, including between the two bytes of a jump, and the counter and any pending page nibble hold. `want_operand` tells the producer that the next byte is a jump operand, so its class field is not used.

Top module: `paged_pc`

## Requirements
- R1: While `rst_n` is low, the next clock edge sets `fetch_addr` to 0x000 and clears `want_operand` and `in_ready`. `in_ready` is 1 from the first edge with `rst_n` high.
- R2: In a cycle without a transfer (`in_valid` and `in_ready` not both high), `fetch_addr` and `want_operand` keep their values.
- R3: An accepted byte of class 0 (sequential), with `want_operand` low, sets `fetch_addr` to `fetch_addr + 1` modulo 4096, so 0xFFF goes to 0x000.
- R4: An accepted byte of class 1 (indirect in-page jump), with `want_operand` low, sets `fetch_addr[7:0]` to `in_pair`. `fetch_addr[11:8]` becomes the page of `fetch_addr + 1`: a jump at 0x0FF with pair 0x15 goes to 0x115, and one at 0xFFF with pair 0x80 goes to 0x080.
- R5: An accepted byte of class 2 (jump), with `want_operand` low, advances `fetch_addr` by one, sets `want_operand`, and latches `in_byte[3:0]` as the target page.
- R6: An accepted byte while `want_operand` is high sets `fetch_addr` to {latched page, `in_byte`} and clears `want_operand`. Its `in_class` has no effect.
- R7: A two-byte jump whose first byte sits at the last location of a page fetches its operand from the first location of the next page (0x0FF then 0x100).
- R8: Stall cycles between the two bytes of a jump keep `want_operand` high and keep the latched page.
- R9: Class 3 (call) moves the counter exactly as class 2 does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Fetched byte present |
| in_ready | output | 1 | Block can consume a byte |
| in_byte | input | 8 | Fetched byte |
| in_class | input | 2 | Decoded class: 0 sequential, 1 indirect in-page, 2 jump, 3 call |
| in_pair | input | 8 | Register-pair value for the indirect jump |
| fetch_addr | output | 12 | Address of the next byte to fetch |
| want_operand | output | 1 | Next byte is the second byte of a jump or call |

## Verification
Every result is due one clock edge after the transfer that causes it, because `fetch_addr`, `want_operand` and `in_ready` come straight from registers. The bench drives inputs on the falling edge and samples on the next falling edge, half a period after the edge that updates the outputs. Stall and reset checks sample after each idle or reset edge. This shows that the held values stay fixed over several cycles and are not only correct after one edge.

// File: rtl/paged_pc_pkg.sv
package paged_pc_pkg;
  typedef enum logic [1:0] {
    CLS_SEQ      = 2'd0,
    CLS_INDIRECT = 2'd1,
    CLS_JUMP     = 2'd2,
    CLS_CALL     = 2'd3
  } instr_cls_e;
endpackage

// File: rtl/pc_step.sv
module pc_step #(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] cur,
  output logic [ADDR_W-1:0] inc
);
  // Plain modulo-2^ADDR_W increment; carry out of the top bit is dropped.
  always_comb inc = cur + {{(ADDR_W-1){1'b0}}, 1'b1};
endmodule

// File: rtl/pc_long_ctrl.sv
module pc_long_ctrl #(
  parameter int HI_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            start_long,
  input  logic [HI_W-1:0] hi_in,
  output logic            pending,
  output logic [HI_W-1:0] hi_q
);
  // Tracks the second byte of a two-byte jump and holds its page nibble.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      hi_q    <= '0;
    end else if (take) begin
      if (pending) begin
        pending <= 1'b0;
      end else if (start_long) begin
        pending <= 1'b1;
        hi_q    <= hi_in;
      end
    end
  end
endmodule

// File: rtl/pc_next_sel.sv
module pc_next_sel
  import paged_pc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 8
) (
  input  logic [ADDR_W-1:0]        pc_inc,
  input  logic                     pending,
  input  logic [ADDR_W-PAGE_W-1:0] hi_q,
  input  instr_cls_e               cls,
  input  logic [PAGE_W-1:0]        byte_in,
  input  logic [PAGE_W-1:0]        pair,
  output logic [ADDR_W-1:0]        next_pc,
  output logic                     start_long
);
  localparam int HI_W = ADDR_W - PAGE_W;

  always_comb begin
    start_long = 1'b0;
    next_pc    = pc_inc;
    if (pending) begin
      next_pc = {hi_q, byte_in};
    end else begin
      unique case (cls)
        CLS_SEQ:      next_pc = pc_inc;
        CLS_INDIRECT: next_pc = {pc_inc[ADDR_W-1:PAGE_W], pair};
        CLS_JUMP, CLS_CALL: begin
          next_pc    = pc_inc;
          start_long = 1'b1;
        end
        default:      next_pc = pc_inc;
      endcase
    end
  end

  // Page nibble must fit within the first byte of a long jump.
  if (HI_W > PAGE_W) begin : g_bad_width
    initial $display("paged_pc: page field wider than a byte");
  end
endmodule

// File: rtl/paged_pc.sv
module paged_pc
  import paged_pc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  input  logic [1:0]        in_class,
  input  logic [7:0]        in_pair,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              want_operand
);
  localparam int HI_W = ADDR_W - PAGE_W;

  logic              take;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_inc;
  logic [ADDR_W-1:0] next_pc;
  logic              start_long;
  logic              pending;
  logic [HI_W-1:0]   hi_q;
  logic              ready_q;

  assign take = in_valid && ready_q;

  pc_step #(.ADDR_W(ADDR_W)) u_step (
    .cur (pc_q),
    .inc (pc_inc)
  );

  pc_next_sel #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_sel (
    .pc_inc     (pc_inc),
    .pending    (pending),
    .hi_q       (hi_q),
    .cls        (instr_cls_e'(in_class)),
    .byte_in    (in_byte[PAGE_W-1:0]),
    .pair       (in_pair[PAGE_W-1:0]),
    .next_pc    (next_pc),
    .start_long (start_long)
  );

  pc_long_ctrl #(.HI_W(HI_W)) u_long (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .start_long (start_long),
    .hi_in      (in_byte[HI_W-1:0]),
    .pending    (pending),
    .hi_q       (hi_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= '0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      if (take) pc_q <= next_pc;
    end
  end

  assign in_ready     = ready_q;
  assign fetch_addr   = pc_q;
  assign want_operand = pending;
endmodule

// File: rtl/paged_pc_chk.sv
module paged_pc_chk #(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [7:0]        in_byte,
  input logic [1:0]        in_class,
  input logic [7:0]        in_pair,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              want_operand
);
  logic              xfer;
  logic [ADDR_W-1:0] addr_plus;
  assign xfer      = in_valid && in_ready;
  assign addr_plus = fetch_addr + {{(ADDR_W-1){1'b0}}, 1'b1};

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (fetch_addr == '0) && !want_operand && !in_ready);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(fetch_addr) && $stable(want_operand));

  a_r3_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !want_operand && in_class == 2'd0) |=> fetch_addr == $past(addr_plus));

  a_r4_indirect_page: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !want_operand && in_class == 2'd1) |=>
      (fetch_addr[PAGE_W-1:0] == $past(in_pair[PAGE_W-1:0])) &&
      (fetch_addr[ADDR_W-1:PAGE_W] == $past(addr_plus[ADDR_W-1:PAGE_W])));

  // R5 and R9: both long classes step by one and wait for an operand
  a_r5_long_first: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !want_operand && in_class[1]) |=>
      want_operand && fetch_addr == $past(addr_plus));

  a_r6_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && want_operand) |=>
      !want_operand && fetch_addr[PAGE_W-1:0] == $past(in_byte[PAGE_W-1:0]));
endmodule

bind paged_pc paged_pc_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_byte      (in_byte),
  .in_class     (in_class),
  .in_pair      (in_pair),
  .fetch_addr   (fetch_addr),
  .want_operand (want_operand)
);

// File: tb/paged_pc_test.sv
module paged_pc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = 8'h00;
  logic [1:0]  in_class = 2'd0;
  logic [7:0]  in_pair = 8'h00;
  logic [11:0] fetch_addr;
  logic        want_operand;

  int runs = 0;
  int fails = 0;

  always #2 clk = ~clk;

  paged_pc uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_class(in_class), .in_pair(in_pair),
    .fetch_addr(fetch_addr), .want_operand(want_operand)
  );

  // {class, byte, pair, expected address, expected want_operand}
  localparam int NV = 19;
  localparam logic [30:0] VEC [NV] = '{
    {2'd0, 8'h00, 8'h00, 12'h001, 1'b0},  // R3 step
    {2'd1, 8'h00, 8'h40, 12'h040, 1'b0},  // R4 same page
    {2'd2, 8'h0A, 8'h00, 12'h041, 1'b1},  // R5 first byte
    {2'd1, 8'hFE, 8'h33, 12'hAFE, 1'b0},  // R6 operand, class ignored
    {2'd0, 8'h00, 8'h00, 12'hAFF, 1'b0},  // R3
    {2'd1, 8'h00, 8'h15, 12'hB15, 1'b0},  // R4 at page end -> next page
    {2'd3, 8'h70, 8'h00, 12'hB16, 1'b1},  // R9 call first byte
    {2'd0, 8'hFF, 8'h00, 12'h0FF, 1'b0},  // R9 call operand
    {2'd1, 8'h00, 8'h15, 12'h115, 1'b0},  // R4 0x0FF + 0x15 -> 0x115
    {2'd2, 8'hFF, 8'h00, 12'h116, 1'b1},  // R5 upper nibble of byte unused
    {2'd0, 8'hFF, 8'h00, 12'hFFF, 1'b0},  // R6
    {2'd0, 8'h00, 8'h00, 12'h000, 1'b0},  // R3 wrap
    {2'd2, 8'h00, 8'h00, 12'h001, 1'b1},  // R5
    {2'd0, 8'hFF, 8'h00, 12'h0FF, 1'b0},  // R6
    {2'd2, 8'h03, 8'h00, 12'h100, 1'b1},  // R7 operand fetched from 0x100
    {2'd2, 8'h21, 8'h00, 12'h321, 1'b0},  // R7/R6 operand class ignored
    {2'd2, 8'h0F, 8'h00, 12'h322, 1'b1},  // R5
    {2'd0, 8'hFF, 8'h00, 12'hFFF, 1'b0},  // R6
    {2'd1, 8'h00, 8'h80, 12'h080, 1'b0}   // R4 at 0xFFF -> page 0
  };

  task automatic chk(input string req, input logic [11:0] got, input logic [11:0] exp);
    runs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %03h expected %03h", req, got, exp);
    end
  endtask

  task automatic send(input logic [1:0] c, input logic [7:0] b, input logic [7:0] p);
    in_valid = 1'b1; in_class = c; in_byte = b; in_pair = p;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 addr in reset", fetch_addr, 12'h000);
    chk("R1 ready in reset", {11'd0, in_ready}, 12'd0);
    chk("R1 operand in reset", {11'd0, want_operand}, 12'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", {11'd0, in_ready}, 12'd1);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][30:29], VEC[i][28:21], VEC[i][20:13]);
      chk($sformatf("vector %0d addr", i), fetch_addr, VEC[i][12:1]);
      chk($sformatf("vector %0d want_operand", i), {11'd0, want_operand}, {11'd0, VEC[i][0]});
    end

    // R2: idle cycles hold the address
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R2 idle hold", fetch_addr, 12'h080);
    end

    // R8: stall between jump bytes keeps the page nibble
    send(2'd2, 8'h05, 8'h00);
    chk("R8 first byte", fetch_addr, 12'h081);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R8 stall operand flag", {11'd0, want_operand}, 12'd1);
      chk("R8 stall addr", fetch_addr, 12'h081);
    end
    send(2'd1, 8'h44, 8'h99);
    chk("R8 operand after stall", fetch_addr, 12'h544);

    // R1: reset in the middle of a jump drops the pending operand
    send(2'd3, 8'h07, 8'h00);
    chk("R1 pre-reset operand flag", {11'd0, want_operand}, 12'd1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-jump reset addr", fetch_addr, 12'h000);
    chk("R1 mid-jump reset flag", {11'd0, want_operand}, 12'd0);
    rst_n = 1'b1;
    @(negedge clk);
    send(2'd0, 8'h12, 8'h00);
    chk("R1 R3 byte after reset is not an operand", fetch_addr, 12'h001);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule